// File: doc/BRIEF.md
# TDM Serial Port with Frame-Format Autodetect

This block connects a 2.048 Mb/s time-division-multiplexed PCM line to parallel logic. The line carries 32 eight-bit channels per 8 kHz frame, timed by a bit clock that runs at twice the data rate. The block runs on a fast system clock. It synchronises the bit clock, the frame pulse and the receive data, then finds the edges of the bit clock.

The block works out the frame format from the polarity of the frame pulse, so no host setting is needed. A low-going pulse selects ST-BUS timing, in which each receive bit is taken on the rising edge three quarters of the way through the bit cell. A high-going pulse selects GCI timing, in which each bit is taken on the falling edge halfway through the cell. Every pulse realigns the bit and channel position.

Each completed receive byte appears with its channel number and a one-cycle strobe. Transmit bytes are written per channel into a holding register ahead of time. They go out most significant bit first. A channel with no byte waiting sends all ones. When pulses stop arriving, the block reports that it has lost framing, stops issuing strobes and holds the line high.

Top module: `tdm_autoframe_port`

## Requirements
- R1: After reset, `no_frame` is 1, `txd` is 1 and `rx_valid` is 0. No `rx_valid` strobe occurs before the first frame pulse is detected.
- R2: The frame pulse is sampled on falling `sclk` edges. A change of level that follows at least 8 stable falling-edge samples is a pulse leading edge. A new level of 0 selects ST-BUS (`fmt_gci`=0) and a new level of 1 selects GCI (`fmt_gci`=1). The falling edge at which the pulse is first seen active starts channel 0 bit 0. `fmt_gci` changes and `no_frame` clears only at such a leading edge.
- R3: In ST-BUS mode, each receive bit is the value of `rxd` at the second rising `sclk` edge of its bit cell, three quarters of the way in.
- R4: In GCI mode, each receive bit is the value of `rxd` at the falling `sclk` edge in the middle of its bit cell.
- R5: A frame is 32 channels of 8 bits, and the channel number rises after each 8 cells. Bytes are assembled most significant bit first. Each byte raises `rx_valid` for exactly one system-clock cycle, with `rx_chan` giving its channel (0 to 31).
- R6: Every detected leading edge restarts the count at channel 0 bit 0, including one that arrives before the current frame is complete.
- R7: A byte written with `tx_wr` for channel n before channel n's first bit cell begins is sent on `txd` most significant bit first, one bit per cell. `txd` changes only just after a cell-boundary falling edge.
- R8: A channel whose byte was not written in time is sent as all ones (8'hFF).
- R9: If more than 1088 bit-clock edges (1024 per frame plus a 64-edge margin) pass with no leading edge, `no_frame` becomes 1. While `no_frame` is 1, `rx_valid` stays 0 and `txd` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sclk |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Bit clock at twice the data rate |
| fp | input | 1 | 8 kHz frame pulse of either polarity |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| rx_valid | output | 1 | One-cycle strobe: received byte ready |
| rx_chan | output | 5 | Channel of the received byte |
| rx_byte | output | 8 | Received byte |
| tx_wr | input | 1 | Write the transmit holding register |
| tx_wr_chan | input | 5 | Channel the written byte belongs to |
| tx_wr_byte | input | 8 | Byte to transmit |
| fmt_gci | output | 1 | Detected format: 0 ST-BUS, 1 GCI |
| no_frame | output | 1 | Framing lost or not yet found |

## Verification
The receive data is driven so that it holds the intended bit only around the sample point of the active format and its inverse at the other candidate edge. A design that samples at the wrong phase or on the wrong clock edge therefore returns every byte inverted. A frame is cut short after ten channels and a fresh pulse follows; a design that does not realign on every pulse delivers the next frame's bytes under shifted channel numbers. The pulse idle level is changed from high to low to test the polarity decision, and some channels are left without a transmit byte to test the all-ones fill. Pulses are then stopped to confirm that strobes cease and the line rises once the edge limit is passed.

// File: rtl/tdm_autoframe_port.sv
`timescale 1ns/1ps
module tdm_autoframe_port #(
  parameter int CHANNELS     = 32,
  parameter int BITS         = 8,
  parameter int MARGIN_EDGES = 64,
  parameter int IDLE_MIN     = 8,
  parameter int SYNC_STAGES  = 2,
  localparam int CH_W = $clog2(CHANNELS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            fp,
  input  logic            rxd,
  output logic            txd,
  output logic            rx_valid,
  output logic [CH_W-1:0] rx_chan,
  output logic [BITS-1:0] rx_byte,
  input  logic            tx_wr,
  input  logic [CH_W-1:0] tx_wr_chan,
  input  logic [BITS-1:0] tx_wr_byte,
  output logic            fmt_gci,
  output logic            no_frame
);
  localparam int BIT_W = $clog2(BITS);
  localparam int POS_W = CH_W + BIT_W + 2;
  localparam int FRAME_EDGES = CHANNELS * BITS * 4;
  localparam int LIMIT = FRAME_EDGES + MARGIN_EDGES;
  localparam int TMR_W = $clog2(LIMIT + 1);
  localparam int RUN_W = $clog2(IDLE_MIN + 1);

  logic [SYNC_STAGES-1:0] sclk_sy, fp_sy, rxd_sy;
  logic sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      fp_sy   <= '0;
      rxd_sy  <= '0;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk};
      fp_sy   <= {fp_sy[SYNC_STAGES-2:0], fp};
      rxd_sy  <= {rxd_sy[SYNC_STAGES-2:0], rxd};
      sclk_d  <= sclk_sy[SYNC_STAGES-1];
    end
  end

  wire sclk_s = sclk_sy[SYNC_STAGES-1];
  wire fp_s   = fp_sy[SYNC_STAGES-1];
  wire rxd_s  = rxd_sy[SYNC_STAGES-1];
  wire rise   = sclk_s & ~sclk_d;
  wire fall   = ~sclk_s & sclk_d;
  wire edge_ev = rise | fall;

  logic             fp_last;
  logic [RUN_W-1:0] run;
  wire fp_chg = fall && (fp_s != fp_last);
  wire lead   = fp_chg && (run == RUN_W'(IDLE_MIN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fp_last <= 1'b0;
      run     <= '0;
      fmt_gci <= 1'b0;
    end else if (fall) begin
      fp_last <= fp_s;
      if (fp_chg) run <= '0;
      else if (run != RUN_W'(IDLE_MIN)) run <= run + 1'b1;
      if (lead) fmt_gci <= fp_s;
    end
  end

  logic [TMR_W-1:0] tmr;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr      <= '0;
      no_frame <= 1'b1;
    end else if (lead) begin
      tmr      <= '0;
      no_frame <= 1'b0;
    end else if (edge_ev && !no_frame) begin
      if (tmr == TMR_W'(LIMIT - 1)) no_frame <= 1'b1;
      else tmr <= tmr + 1'b1;
    end
  end

  logic [POS_W-1:0] pos;
  wire [POS_W-1:0] npos = lead ? '0 : pos + 1'b1;
  wire [1:0]       nq   = npos[1:0];
  wire [BIT_W-1:0] nbit = npos[BIT_W+1:2];
  wire [CH_W-1:0]  nch  = npos[POS_W-1:BIT_W+2];

  always_ff @(posedge clk) begin
    if (!rst_n) pos <= '0;
    else if (edge_ev) pos <= npos;
  end

  wire samp = fmt_gci ? (fall && nq == 2'd2) : (rise && nq == 2'd3);
  wire last_bit = (nbit == BIT_W'(BITS - 1));
  logic [BITS-1:0] sh_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_in    <= '0;
      rx_valid <= 1'b0;
      rx_chan  <= '0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= samp && last_bit && !no_frame;
      if (samp) begin
        sh_in <= {sh_in[BITS-2:0], rxd_s};
        if (last_bit) begin
          rx_byte <= {sh_in[BITS-2:0], rxd_s};
          rx_chan <= nch;
        end
      end
    end
  end

  wire bnd = fall && nq == 2'd0;
  logic            hold_v;
  logic [CH_W-1:0] hold_ch;
  logic [BITS-1:0] hold_byte, tx_sh;
  logic            tx_bit;
  wire hold_hit = hold_v && hold_ch == nch;
  wire [BITS-1:0] tx_word = hold_hit ? hold_byte : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_ch   <= '0;
      hold_byte <= '0;
    end else if (tx_wr) begin
      hold_v    <= 1'b1;
      hold_ch   <= tx_wr_chan;
      hold_byte <= tx_wr_byte;
    end else if (bnd && nbit == '0 && hold_hit) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_bit <= 1'b1;
      tx_sh  <= '1;
    end else if (bnd) begin
      if (nbit == '0) begin
        tx_bit <= tx_word[BITS-1];
        tx_sh  <= {tx_word[BITS-2:0], 1'b1};
      end else begin
        tx_bit <= tx_sh[BITS-1];
        tx_sh  <= {tx_sh[BITS-2:0], 1'b1};
      end
    end
  end

  assign txd = no_frame | tx_bit;

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R9
  no_strobe_unframed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_frame |=> !rx_valid);

  // R7
  tx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(txd) && $stable(no_frame)) |-> $past(fall));

  // R2
  mode_on_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_gci) |-> $past(lead));

  // R2
  lock_on_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(no_frame) |-> $past(lead));
endmodule

// File: tb/tdm_autoframe_port_tb.sv
`timescale 1ns/1ps
module tdm_autoframe_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, fp = 1'b1, rxd = 1'b1;
  logic tx_wr = 1'b0;
  logic [4:0] tx_wr_chan = '0;
  logic [7:0] tx_wr_byte = '0;
  logic txd, rx_valid, fmt_gci, no_frame;
  logic [4:0] rx_chan;
  logic [7:0] rx_byte;

  always #5 clk = ~clk;

  tdm_autoframe_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fp(fp), .rxd(rxd), .txd(txd),
    .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_byte(rx_byte),
    .tx_wr(tx_wr), .tx_wr_chan(tx_wr_chan), .tx_wr_byte(tx_wr_byte),
    .fmt_gci(fmt_gci), .no_frame(no_frame)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] got [32];
  bit got_v [32];
  int strobes = 0;
  logic [7:0] tx_cap [32];
  bit txd_low = 1'b0;

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      got[rx_chan] = rx_byte;
      got_v[rx_chan] = 1'b1;
      strobes = strobes + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_edges(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; w(2);
      if (txd == 1'b0) txd_low = 1'b1;
      w(2);
      sclk = 1'b1; w(4);
    end
  endtask

  task automatic do_frame(input bit gci, input int nch, input int seed,
                          input bit do_check, output bit frame_ok);
    logic [7:0] rx_pat [32];
    logic [7:0] tx_pat [32];
    bit tx_en [32];
    int f0;
    for (int c = 0; c < 32; c++) begin
      rx_pat[c] = 8'(c * 29 + seed * 7 + 8'h5A);
      tx_pat[c] = 8'(c * 53 + seed * 11 + 3);
      tx_en[c]  = (c == 0) || (((c + seed) % 5) != 0);
      got_v[c] = 1'b0;
      tx_cap[c] = '0;
    end
    strobes = 0;
    tx_wr_chan = 5'd0; tx_wr_byte = tx_pat[0]; tx_wr = 1'b1; w(1); tx_wr = 1'b0; w(1);
    fp = gci ? 1'b1 : 1'b0; w(2);
    for (int c = 0; c < nch; c++) begin
      for (int b = 0; b < 8; b++) begin
        logic bv;
        bv = rx_pat[c][7 - b];
        sclk = 1'b0; w(2);
        if (b == 4 && c < 31 && tx_en[c + 1]) begin
          tx_wr_chan = 5'(c + 1); tx_wr_byte = tx_pat[c + 1];
          tx_wr = 1'b1; w(1); tx_wr = 1'b0; w(1);
        end else w(2);
        sclk = 1'b1; w(2); rxd = gci ? bv : ~bv; w(2);
        sclk = 1'b0; w(2); rxd = gci ? ~bv : bv;
        tx_cap[c] = {tx_cap[c][6:0], txd};
        if (c == 0 && b == 0) fp = gci ? 1'b0 : 1'b1;
        w(2);
        sclk = 1'b1; w(4);
      end
    end
    frame_ok = 1'b1;
    if (do_check) begin
      f0 = fails;
      chk(strobes == 32, "R5 strobe count", strobes, 32);
      chk(fmt_gci == gci, "R2 detected format", int'(fmt_gci), int'(gci));
      chk(!no_frame, "R2 framing found", int'(no_frame), 0);
      for (int c = 0; c < 32; c++) begin
        logic [7:0] te;
        chk(got_v[c] && got[c] == rx_pat[c], gci ? "R4 GCI rx byte" : "R3 ST-BUS rx byte",
            int'(got[c]), int'(rx_pat[c]));
        te = tx_en[c] ? tx_pat[c] : 8'hFF;
        chk(tx_cap[c] == te, tx_en[c] ? "R7 tx byte" : "R8 unloaded all ones",
            int'(tx_cap[c]), int'(te));
      end
      frame_ok = (fails == f0);
    end
  endtask

  task automatic t_reset;
    chk(no_frame == 1'b1, "R1 no_frame after reset", int'(no_frame), 1);
    chk(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(rx_valid == 1'b0, "R1 rx_valid after reset", int'(rx_valid), 0);
    txd_low = 1'b0; strobes = 0;
    idle_edges(24);
    chk(strobes == 0, "R1 no strobe before pulse", strobes, 0);
    chk(!txd_low, "R1 txd high before pulse", int'(txd_low), 0);
  endtask

  task automatic t_stbus;
    bit ok;
    do_frame(1'b0, 32, 1, 1'b1, ok);
    do_frame(1'b0, 32, 2, 1'b1, ok);
  endtask

  task automatic t_resync;
    bit ok;
    do_frame(1'b0, 10, 3, 1'b0, ok);
    do_frame(1'b0, 32, 4, 1'b1, ok);
    chk(ok, "R6 early pulse realigns frame", int'(ok), 1);
  endtask

  task automatic t_gci;
    bit ok;
    fp = 1'b0;
    idle_edges(16);
    do_frame(1'b1, 32, 5, 1'b1, ok);
    do_frame(1'b1, 32, 6, 1'b1, ok);
  endtask

  task automatic t_timeout;
    chk(no_frame == 1'b0, "R9 still framed after full frame", int'(no_frame), 0);
    idle_edges(40);
    chk(no_frame == 1'b1, "R9 no_frame after edge limit", int'(no_frame), 1);
    strobes = 0; txd_low = 1'b0;
    idle_edges(64);
    chk(strobes == 0, "R9 strobes suppressed", strobes, 0);
    chk(!txd_low, "R9 txd held high", int'(txd_low), 0);
  endtask

  initial begin
    w(4);
    rst_n = 1'b1;
    w(2);
    t_reset();
    t_stbus();
    t_resync();
    t_gci();
    t_timeout();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule